// File: doc/BRIEF.md
# Line Access Switch State Controller

This block is the digital control core of a solid-state switch array that connects a telephone line to its line circuit, to a ringing generator and to test buses. Three command inputs (ring, test-in, test-out) pick one of eight switch configurations. A hold input freezes the selected configuration. The result drives enables for five switch groups: the line break pair, ring return plus ring access, the ringing-generator test pair, the test-in pair and the test-out pair. Ring return and ring access have separate enables because the ring access switch can only release at a current zero crossing.

Three safety conditions force every switch open, and each one takes effect whether or not the command is held. The first is an external shutdown pin driven low. The second is an over-temperature flag. The third is a battery monitor with hysteresis. When the condition clears, the switches return to the commanded (or held) configuration. Once the ring access switch is on, it stays on until a ring-current zero-crossing pulse arrives. This gives make-before-break behaviour when the line leaves ringing. A parameter selects the base or the extended decode. They differ only in the all-high command.

The commands, the hold input and the zero-cross pulse are synchronous to `clk`. The shutdown pin, the temperature flag and the three battery flags are asynchronous and pass through two-flop synchronizers.

Top module: `line_sw_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters the all-off state. In that state `state_code` is 6, all six enables are 0 and `sd_status` is 1.
- R2: Each state is defined by its command {ring, tin, tout}, its code and the enables it drives. A command change appears on the outputs after one clock edge.
  - {000} idle, code 0, break only.
  - {001} test-out, code 1, test-out only.
  - {010} test-in, code 2, test-in only.
  - {100} ringing, code 3, ring return and ring access.
  - {110} generator test, code 4, ring-test only.
  - {011} test-out plus test-in, code 5, both test enables.
  - {101} all-off, code 6, no enables.
- R3: Command {111} decodes to all-off (code 6) when `EXTENDED` is 0. When `EXTENDED` is 1 it decodes to test-out plus ring-test (code 7), with the test-out and ring-test enables set.
- R4: While `hold` is low the command passes straight through. When `hold` rises, the command present in the last cycle it was low is kept. Command changes have no effect while `hold` stays high.
- R5: A low `sd_force_n` forces all-off (code 6) even while `hold` is high. Releasing it restores the held or live command.
- R6: A high `ot_flag` forces all-off and drives `sd_status` low. Clearing it restores the previous configuration and drives `sd_status` high.
- R7: A high `bat_high` or `bat_lost` forces all-off. The block stays all-off after both drop and only leaves all-off once `bat_ok_low` is high.
- R8: The ring access enable turns on together with ringing. After ringing ends it stays on, whatever the state, until a cycle in which `zc_pulse` is high. Ring return turns off together with ringing. A zero-cross pulse during ringing has no effect.
- R9: If ringing is commanded again while a ring access release is pending, the pending release is cancelled and a later zero-cross pulse leaves the enable on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_ring | input | 1 | Ring command bit |
| cmd_tin | input | 1 | Test-in command bit |
| cmd_tout | input | 1 | Test-out command bit |
| hold | input | 1 | High freezes the command, low is transparent |
| sd_force_n | input | 1 | Asynchronous; low forces all-off |
| ot_flag | input | 1 | Asynchronous over-temperature flag |
| bat_high | input | 1 | Asynchronous; battery less negative than the upper threshold |
| bat_lost | input | 1 | Asynchronous; battery missing |
| bat_ok_low | input | 1 | Asynchronous; battery more negative than the lower threshold |
| zc_pulse | input | 1 | One-cycle ring-current zero-crossing pulse |
| en_break | output | 1 | Line break pair enable |
| en_ring_ret | output | 1 | Ring return enable |
| en_ring_acc | output | 1 | Ring access enable (delayed release) |
| en_ringtest | output | 1 | Ringing-generator test pair enable |
| en_tin | output | 1 | Test-in pair enable |
| en_tout | output | 1 | Test-out pair enable |
| sd_status | output | 1 | High normally, low during thermal shutdown |
| state_code | output | 3 | Current state code |

## Verification
The bench targets four corner cases.

- **Hold edge.** The command changes in the same cycle that `hold` rises. A latch that captured one cycle late would freeze the new command instead of the old one.
- **Battery hysteresis.** `bat_high` falls while `bat_ok_low` is still low. A monitor without hysteresis would reconnect the line too early.
- **Make-before-break release.** After ringing ends, the ring access enable must stay on for several cycles. A design that followed the decode directly would drop it at once, and one that ignored `zc_pulse` would never drop it.
- **Re-entry while pending.** Ringing is commanded again while a release is pending, and a later zero-cross pulse must not open the switch during ringing.

The extended code {111} is checked on both variants at once, so a variant mix-up shows as a mismatch.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_TOUT     = 3'd1,
        ST_TIN      = 3'd2,
        ST_RING     = 3'd3,
        ST_RGTEST   = 3'd4,
        ST_TOUT_TIN = 3'd5,
        ST_ALLOFF   = 3'd6,
        ST_TOUT_RGT = 3'd7
    } lsw_state_e;

    typedef struct packed {
        logic ring;
        logic tin;
        logic tout;
    } lsw_cmd_t;

    typedef struct packed {
        logic brk;
        logic ring_ret;
        logic ringtest;
        logic tin;
        logic tout;
    } lsw_en_t;

    localparam lsw_en_t EN_NONE = '0;

endpackage

// File: rtl/lsw_sync.sv
module lsw_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lsw_cmd_hold.sv
module lsw_cmd_hold
    import lsw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hold,
    input  lsw_cmd_t live,
    output lsw_cmd_t eff
);
    lsw_cmd_t held_q;

    // Tracks the live command while transparent; frozen once hold is high.
    always_ff @(posedge clk) begin
        if (!rst_n)     held_q <= '0;
        else if (!hold) held_q <= live;
    end

    assign eff = hold ? held_q : live;
endmodule

// File: rtl/lsw_bat_mon.sv
module lsw_bat_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic too_high,
    input  logic lost,
    input  logic low_ok,
    output logic fault
);
    // Set by either upper condition, cleared only by the lower threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)                fault <= 1'b0;
        else if (too_high || lost) fault <= 1'b1;
        else if (low_ok)           fault <= 1'b0;
    end
endmodule

// File: rtl/lsw_acc_hold.sv
module lsw_acc_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_next,
    input  logic zc,
    output logic acc_on
);
    // A ringing command wins over the zero-cross pulse, which cancels any pending release.
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_on <= 1'b0;
        else if (ring_next) acc_on <= 1'b1;
        else if (zc)        acc_on <= 1'b0;
    end
endmodule

// File: rtl/line_sw_ctrl.sv
module line_sw_ctrl
    import lsw_pkg::*;
#(
    parameter bit EXTENDED    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_ring,
    input  logic       cmd_tin,
    input  logic       cmd_tout,
    input  logic       hold,
    input  logic       sd_force_n,
    input  logic       ot_flag,
    input  logic       bat_high,
    input  logic       bat_lost,
    input  logic       bat_ok_low,
    input  logic       zc_pulse,
    output logic       en_break,
    output logic       en_ring_ret,
    output logic       en_ring_acc,
    output logic       en_ringtest,
    output logic       en_tin,
    output logic       en_tout,
    output logic       sd_status,
    output logic [2:0] state_code
);
    localparam int NFLAG = 5;
    // Flag order: {sd_force_n, ot_flag, bat_high, bat_lost, bat_ok_low}
    localparam logic [NFLAG-1:0] FLAG_RST = 5'b1_0_0_0_1;

    logic [NFLAG-1:0] flag_raw, flag_s;
    logic sd_sync, ot_sync, bat_high_s, bat_lost_s, bat_ok_s;
    logic bat_fault, override_all, acc_on, sd_status_q;
    lsw_cmd_t   live_cmd, eff_cmd;
    lsw_state_e cmd_state, next_state, state_q, spare_state;
    lsw_en_t    en_vec;

    assign flag_raw = {sd_force_n, ot_flag, bat_high, bat_lost, bat_ok_low};

    lsw_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES), .RST_VAL(FLAG_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(flag_raw), .q(flag_s)
    );

    assign {sd_sync, ot_sync, bat_high_s, bat_lost_s, bat_ok_s} = flag_s;

    assign live_cmd = '{ring: cmd_ring, tin: cmd_tin, tout: cmd_tout};

    lsw_cmd_hold u_hold (
        .clk(clk), .rst_n(rst_n), .hold(hold), .live(live_cmd), .eff(eff_cmd)
    );

    lsw_bat_mon u_bat (
        .clk(clk), .rst_n(rst_n), .too_high(bat_high_s), .lost(bat_lost_s),
        .low_ok(bat_ok_s), .fault(bat_fault)
    );

    generate
        if (EXTENDED) begin : g_ext
            assign spare_state = ST_TOUT_RGT;
        end else begin : g_base
            assign spare_state = ST_ALLOFF;
        end
    endgenerate

    always_comb begin
        unique case ({eff_cmd.ring, eff_cmd.tin, eff_cmd.tout})
            3'b000:  cmd_state = ST_IDLE;
            3'b001:  cmd_state = ST_TOUT;
            3'b010:  cmd_state = ST_TIN;
            3'b011:  cmd_state = ST_TOUT_TIN;
            3'b100:  cmd_state = ST_RING;
            3'b101:  cmd_state = ST_ALLOFF;
            3'b110:  cmd_state = ST_RGTEST;
            default: cmd_state = spare_state;
        endcase
    end

    assign override_all = !sd_sync || ot_sync || bat_fault;
    assign next_state   = override_all ? ST_ALLOFF : cmd_state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_ALLOFF;
            sd_status_q <= 1'b1;
        end else begin
            state_q     <= next_state;
            sd_status_q <= !ot_sync;
        end
    end

    lsw_acc_hold u_acc (
        .clk(clk), .rst_n(rst_n), .ring_next(next_state == ST_RING),
        .zc(zc_pulse), .acc_on(acc_on)
    );

    always_comb begin
        en_vec = EN_NONE;
        unique case (state_q)
            ST_IDLE:     en_vec.brk      = 1'b1;
            ST_TOUT:     en_vec.tout     = 1'b1;
            ST_TIN:      en_vec.tin      = 1'b1;
            ST_RING:     en_vec.ring_ret = 1'b1;
            ST_RGTEST:   en_vec.ringtest = 1'b1;
            ST_TOUT_TIN: begin
                en_vec.tin  = 1'b1;
                en_vec.tout = 1'b1;
            end
            ST_TOUT_RGT: begin
                en_vec.ringtest = 1'b1;
                en_vec.tout     = 1'b1;
            end
            default:     en_vec = EN_NONE;
        endcase
    end

    assign en_break    = en_vec.brk;
    assign en_ring_ret = en_vec.ring_ret;
    assign en_ring_acc = acc_on;
    assign en_ringtest = en_vec.ringtest;
    assign en_tin      = en_vec.tin;
    assign en_tout     = en_vec.tout;
    assign sd_status   = sd_status_q;
    assign state_code  = state_q;
endmodule

// File: rtl/line_sw_ctrl_chk.sv
module line_sw_ctrl_chk #(
    parameter bit EXTENDED = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       zc_pulse,
    input logic       en_break,
    input logic       en_ring_ret,
    input logic       en_ring_acc,
    input logic       en_ringtest,
    input logic       en_tin,
    input logic       en_tout,
    input logic       sd_status,
    input logic [2:0] state_code,
    input logic       sd_s,
    input logic       ot_s,
    input logic       bat_fault
);
    a_r2_break_alone: assert property (@(posedge clk) disable iff (!rst_n)
        en_break |-> !(en_ring_ret || en_ringtest || en_tin || en_tout));

    a_r2_exclusive_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_break, en_ring_ret, en_ringtest}));

    a_r3_base_no_spare: assert property (@(posedge clk) disable iff (!rst_n)
        !EXTENDED |-> state_code != 3'd7);

    a_r5_pin_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_s |=> state_code == 3'd6);

    a_r6_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
        ot_s |=> (state_code == 3'd6 && !sd_status));

    a_r7_battery_off: assert property (@(posedge clk) disable iff (!rst_n)
        bat_fault |=> state_code == 3'd6);

    a_r8_acc_waits_zc: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ring_acc && !zc_pulse) |=> en_ring_acc);

    a_r8_return_with_access: assert property (@(posedge clk) disable iff (!rst_n)
        en_ring_ret |-> en_ring_acc);
endmodule

bind line_sw_ctrl line_sw_ctrl_chk #(.EXTENDED(EXTENDED)) u_chk (
    .clk(clk), .rst_n(rst_n), .zc_pulse(zc_pulse),
    .en_break(en_break), .en_ring_ret(en_ring_ret), .en_ring_acc(en_ring_acc),
    .en_ringtest(en_ringtest), .en_tin(en_tin), .en_tout(en_tout),
    .sd_status(sd_status), .state_code(state_code),
    .sd_s(sd_sync), .ot_s(ot_sync), .bat_fault(bat_fault)
);

// File: tb/line_sw_ctrl_tb.sv
module line_sw_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, cmd_ring, cmd_tin, cmd_tout, hold;
    logic sd_force_n, ot_flag, bat_high, bat_lost, bat_ok_low, zc_pulse;
    logic d_brk, d_ret, d_acc, d_rgt, d_tin, d_tout, d_sd;
    logic b_brk, b_ret, b_acc, b_rgt, b_tin, b_tout, b_sd;
    logic [2:0] d_code, b_code;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_sw_ctrl #(.EXTENDED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_ring(cmd_ring), .cmd_tin(cmd_tin),
        .cmd_tout(cmd_tout), .hold(hold), .sd_force_n(sd_force_n),
        .ot_flag(ot_flag), .bat_high(bat_high), .bat_lost(bat_lost),
        .bat_ok_low(bat_ok_low), .zc_pulse(zc_pulse),
        .en_break(d_brk), .en_ring_ret(d_ret), .en_ring_acc(d_acc),
        .en_ringtest(d_rgt), .en_tin(d_tin), .en_tout(d_tout),
        .sd_status(d_sd), .state_code(d_code)
    );

    line_sw_ctrl #(.EXTENDED(1'b0)) u_base (
        .clk(clk), .rst_n(rst_n), .cmd_ring(cmd_ring), .cmd_tin(cmd_tin),
        .cmd_tout(cmd_tout), .hold(hold), .sd_force_n(sd_force_n),
        .ot_flag(ot_flag), .bat_high(bat_high), .bat_lost(bat_lost),
        .bat_ok_low(bat_ok_low), .zc_pulse(zc_pulse),
        .en_break(b_brk), .en_ring_ret(b_ret), .en_ring_acc(b_acc),
        .en_ringtest(b_rgt), .en_tin(b_tin), .en_tout(b_tout),
        .sd_status(b_sd), .state_code(b_code)
    );

    // Enable order: {break, ring_ret, ring_acc, ringtest, tin, tout}
    function automatic logic [5:0] exp_en(input logic [2:0] code);
        case (code)
            3'd0:    return 6'b100000;
            3'd1:    return 6'b000001;
            3'd2:    return 6'b000010;
            3'd3:    return 6'b011000;
            3'd4:    return 6'b000100;
            3'd5:    return 6'b000011;
            3'd7:    return 6'b000101;
            default: return 6'b000000;
        endcase
    endfunction

    function automatic logic [2:0] exp_code(input logic [2:0] c, input bit ext);
        case (c)
            3'b000:  return 3'd0;
            3'b001:  return 3'd1;
            3'b010:  return 3'd2;
            3'b011:  return 3'd5;
            3'b100:  return 3'd3;
            3'b101:  return 3'd6;
            3'b110:  return 3'd4;
            default: return ext ? 3'd7 : 3'd6;
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Checks extended instance: {code, enables}
    task automatic chk_d(input string req, input logic [2:0] code, input logic [5:0] en);
        check(req, {d_code, d_brk, d_ret, d_acc, d_rgt, d_tin, d_tout}, {code, en});
    endtask

    task automatic chk_b(input string req, input logic [2:0] code, input logic [5:0] en);
        check(req, {b_code, b_brk, b_ret, b_acc, b_rgt, b_tin, b_tout}, {code, en});
    endtask

    task automatic set_cmd(input logic [2:0] c);
        {cmd_ring, cmd_tin, cmd_tout} = c;
    endtask

    task automatic pulse_zc();
        zc_pulse = 1'b1;
        @(posedge clk);
        @(negedge clk);
        zc_pulse = 1'b0;
    endtask

    task automatic t_reset();
        step(3);
        chk_d("R1 reset state", 3'd6, 6'b000000);
        check("R1 reset sd_status", {8'd0, d_sd}, 9'd1);
        rst_n = 1'b1;
    endtask

    // R2 and R3: sweep all command codes on both variants
    task automatic t_decode();
        zc_pulse = 1'b1;
        for (int i = 0; i < 8; i++) begin
            set_cmd(i[2:0]);
            step(2);
            chk_d($sformatf("R2/R3 ext cmd %03b", i[2:0]),
                  exp_code(i[2:0], 1'b1), exp_en(exp_code(i[2:0], 1'b1)));
            chk_b($sformatf("R2/R3 base cmd %03b", i[2:0]),
                  exp_code(i[2:0], 1'b0), exp_en(exp_code(i[2:0], 1'b0)));
        end
        zc_pulse = 1'b0;
        set_cmd(3'b000);
        step(1);
        chk_d("R2 one edge latency to idle", 3'd0, 6'b100000);
    endtask

    task automatic t_hold();
        set_cmd(3'b001);
        step(2);
        chk_d("R4 transparent", 3'd1, exp_en(3'd1));
        hold = 1'b1;
        set_cmd(3'b010);
        step(3);
        chk_d("R4 capture on rise", 3'd1, exp_en(3'd1));
        set_cmd(3'b100);
        step(3);
        chk_d("R4 changes ignored", 3'd1, exp_en(3'd1));
        hold = 1'b0;
        step(1);
        chk_d("R4 release follows live", 3'd3, exp_en(3'd3));
        set_cmd(3'b000);
        pulse_zc();
        chk_d("R4 back to idle", 3'd0, exp_en(3'd0));
    endtask

    task automatic t_pin();
        set_cmd(3'b001);
        step(2);
        hold = 1'b1;
        set_cmd(3'b000);
        sd_force_n = 1'b0;
        step(5);
        chk_d("R5 pin forces off while held", 3'd6, 6'b000000);
        sd_force_n = 1'b1;
        step(5);
        chk_d("R5 release restores held", 3'd1, exp_en(3'd1));
        hold = 1'b0;
        step(2);
        chk_d("R5 live after hold", 3'd0, exp_en(3'd0));
    endtask

    task automatic t_thermal();
        set_cmd(3'b010);
        step(2);
        ot_flag = 1'b1;
        step(5);
        chk_d("R6 thermal off", 3'd6, 6'b000000);
        check("R6 sd_status low", {8'd0, d_sd}, 9'd0);
        ot_flag = 1'b0;
        step(5);
        chk_d("R6 restore", 3'd2, exp_en(3'd2));
        check("R6 sd_status high", {8'd0, d_sd}, 9'd1);
    endtask

    task automatic t_battery();
        set_cmd(3'b000);
        bat_high = 1'b1;
        bat_ok_low = 1'b0;
        step(6);
        chk_d("R7 high battery off", 3'd6, 6'b000000);
        bat_high = 1'b0;
        step(6);
        chk_d("R7 hysteresis keeps off", 3'd6, 6'b000000);
        bat_ok_low = 1'b1;
        step(6);
        chk_d("R7 recover at low threshold", 3'd0, exp_en(3'd0));
        bat_lost = 1'b1;
        step(6);
        chk_d("R7 lost battery off", 3'd6, 6'b000000);
        bat_lost = 1'b0;
        step(6);
        chk_d("R7 recover after loss", 3'd0, exp_en(3'd0));
    endtask

    task automatic t_ring_release();
        set_cmd(3'b100);
        step(2);
        pulse_zc();
        chk_d("R8 zc during ringing ignored", 3'd3, 6'b011000);
        set_cmd(3'b000);
        step(1);
        chk_d("R8 access held after ringing", 3'd0, 6'b101000);
        step(5);
        chk_d("R8 access still held", 3'd0, 6'b101000);
        pulse_zc();
        chk_d("R8 release at zero cross", 3'd0, 6'b100000);
    endtask

    task automatic t_cancel();
        set_cmd(3'b100);
        step(2);
        set_cmd(3'b010);
        step(2);
        chk_d("R9 pending in test-in", 3'd2, 6'b001010);
        set_cmd(3'b100);
        step(1);
        pulse_zc();
        chk_d("R9 cancel keeps access", 3'd3, 6'b011000);
        set_cmd(3'b000);
        step(1);
        pulse_zc();
        chk_d("R9 later release", 3'd0, 6'b100000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hold = 1'b0; zc_pulse = 1'b0;
        sd_force_n = 1'b1; ot_flag = 1'b0;
        bat_high = 1'b0; bat_lost = 1'b0; bat_ok_low = 1'b1;
        set_cmd(3'b000);
        @(negedge clk);
        t_reset();
        step(4);
        t_decode();
        t_hold();
        t_pin();
        t_thermal();
        t_battery();
        t_ring_release();
        t_cancel();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule